// File: doc/BRIEF.md
# Operand Effective Address Generator

This unit sits beside the decoder of a small 8-bit accumulator processor. Once the decoder has classified an instruction, it hands this block an addressing-mode code together with the one or two bytes that follow the opcode, the 16-bit index pair H:X, the stack pointer, the address of the next instruction and a flag that says whether a stack-mode prebyte (0x9E) came before the opcode. The block then works out where the operand lives. It also reports how many bytes the instruction occupies, the branch destination, and the new value of H:X for the modes that step the index after the access.

Each request is a single-cycle `start` strobe. All results are captured in registers on that edge. They appear with a one-cycle `done` pulse and stay unchanged until the next strobe. Every 16-bit sum wraps modulo 65536. A stack-relative mode without its prebyte, or an unassigned mode code, is flagged as illegal and leaves H:X untouched.

Top module: `ea_gen`

## Requirements
- R1: Mode code 2 (page-zero direct) yields an address whose high byte is 0x00 and whose low byte is the first operand byte, with length 2.
- R2: Mode code 3 (extended) yields the address {first byte, second byte}, with the first byte as the high half, and length 3.
- R3: Mode code 4 (relative) treats the first byte as a two's-complement displacement from -128 to +127. The branch target is the next-instruction address plus that displacement, modulo 65536. The address output carries the same value and the length is 2.
- R4: Mode codes 5, 6 and 7 (indexed) yield H:X, H:X plus the unsigned first byte, and H:X plus the unsigned {first, second} word, with lengths 1, 2 and 3. Every sum wraps modulo 65536.
- R5: Mode codes 10 and 11 (stack-relative) with the prebyte flag set yield the stack pointer plus the unsigned first byte, or plus the unsigned {first, second} word, modulo 65536. Their lengths are 3 and 4, because the prebyte counts as one byte.
- R6: Mode codes 8 and 9 (post-increment indexed) yield H:X and H:X plus the unsigned first byte, with lengths 1 and 2. The address is formed from the H:X value before the step. The H:X write enable is 1 and the new H:X is the old value plus one, so 0xFFFF becomes 0x0000.
- R7: Mode code 0 (inherent) gives address 0, length 1 and a cleared immediate flag. Mode code 1 (immediate) gives address 0, length 2, a set immediate flag and the first operand byte on the data output. In all other modes the data output is 0x00.
- R8: Mode codes 0 through 7 leave the H:X write enable at 0 and return the new H:X equal to the input H:X.
- R9: Mode code 10 or 11 without the prebyte flag, or any mode code from 12 to 15, sets the illegal flag. In that case the write enable is 0, the new H:X equals the input H:X, the length is 0 and the address is 0.
- R10: After reset every output is 0. Results appear, with `done` high for exactly one cycle, on the clock edge after the one that samples `start`, and they hold until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, one cycle |
| mode | input | 4 | Addressing-mode code |
| prebyte | input | 1 | Stack-mode prebyte seen |
| hx | input | 16 | Index pair H:X |
| sp | input | 16 | Stack pointer |
| pc_next | input | 16 | Address of the next instruction |
| opb1 | input | 8 | First byte after the opcode |
| opb2 | input | 8 | Second byte after the opcode |
| done | output | 1 | Results valid, one-cycle pulse |
| ea | output | 16 | Effective address |
| imm_flag | output | 1 | Operand is immediate data |
| imm_data | output | 8 | Immediate operand value |
| inst_len | output | 3 | Instruction length in bytes |
| br_target | output | 16 | Branch destination |
| hx_next | output | 16 | H:X value after the instruction |
| hx_we | output | 1 | H:X must be written back |
| illegal | output | 1 | Illegal mode request |

## Verification
In the post-increment modes, address formation and the index step land in the same result cycle. Both read the same H:X input, and only one of them may see the stepped value. The bench provokes this with H:X at 0xFFFF, in both the no-offset form and the 8-bit-offset form. It passes only if the address comes from the unstepped value and wraps, while the new H:X rolls over to 0x0000 in that same `done` cycle. A second collision, an illegal stack request arriving while the write enable could have fired, is judged by expecting the write enable at 0 and the new H:X equal to the input.

// File: rtl/ea_gen.sv
module ea_gen #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [3:0]    mode,
  input  logic          prebyte,
  input  logic [AW-1:0] hx,
  input  logic [AW-1:0] sp,
  input  logic [AW-1:0] pc_next,
  input  logic [DW-1:0] opb1,
  input  logic [DW-1:0] opb2,
  output logic          done,
  output logic [AW-1:0] ea,
  output logic          imm_flag,
  output logic [DW-1:0] imm_data,
  output logic [LW-1:0] inst_len,
  output logic [AW-1:0] br_target,
  output logic [AW-1:0] hx_next,
  output logic          hx_we,
  output logic          illegal
);
  localparam logic [3:0] M_INH = 4'd0, M_IMM = 4'd1, M_DIR = 4'd2, M_EXT = 4'd3,
                         M_REL = 4'd4, M_IX0 = 4'd5, M_IX1 = 4'd6, M_IX2 = 4'd7,
                         M_IXP = 4'd8, M_IX1P = 4'd9, M_SP1 = 4'd10, M_SP2 = 4'd11;

  logic [AW-1:0] off8, off16, rel_sum, n_ea;
  logic [LW-1:0] n_len;
  logic          n_imm, n_we, n_ill;

  assign off8    = AW'(opb1);
  assign off16   = AW'({opb1, opb2});
  assign rel_sum = pc_next + {{(AW-DW){opb1[DW-1]}}, opb1};

  always_comb begin
    n_ea  = '0;
    n_len = '0;
    n_imm = 1'b0;
    n_we  = 1'b0;
    n_ill = 1'b0;
    case (mode)
      M_INH:  n_len = LW'(1);
      M_IMM:  begin n_len = LW'(2); n_imm = 1'b1; end
      M_DIR:  begin n_len = LW'(2); n_ea = off8; end
      M_EXT:  begin n_len = LW'(3); n_ea = off16; end
      M_REL:  begin n_len = LW'(2); n_ea = rel_sum; end
      M_IX0:  begin n_len = LW'(1); n_ea = hx; end
      M_IX1:  begin n_len = LW'(2); n_ea = hx + off8; end
      M_IX2:  begin n_len = LW'(3); n_ea = hx + off16; end
      M_IXP:  begin n_len = LW'(1); n_ea = hx; n_we = 1'b1; end
      M_IX1P: begin n_len = LW'(2); n_ea = hx + off8; n_we = 1'b1; end
      M_SP1:  if (prebyte) begin n_len = LW'(3); n_ea = sp + off8; end
              else n_ill = 1'b1;
      M_SP2:  if (prebyte) begin n_len = LW'(4); n_ea = sp + off16; end
              else n_ill = 1'b1;
      default: n_ill = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      ea        <= '0;
      imm_flag  <= 1'b0;
      imm_data  <= '0;
      inst_len  <= '0;
      br_target <= '0;
      hx_next   <= '0;
      hx_we     <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        ea        <= n_ea;
        imm_flag  <= n_imm;
        imm_data  <= n_imm ? opb1 : '0;
        inst_len  <= n_len;
        br_target <= rel_sum;
        hx_next   <= n_we ? hx + AW'(1) : hx;
        hx_we     <= n_we;
        illegal   <= n_ill;
      end
    end
  end
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [3:0]    mode,
  input logic [AW-1:0] hx,
  input logic [DW-1:0] opb1,
  input logic          done,
  input logic [AW-1:0] ea,
  input logic          imm_flag,
  input logic [DW-1:0] imm_data,
  input logic [AW-1:0] hx_next,
  input logic          hx_we,
  input logic          illegal
);
  p_done_after_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);
  p_page_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mode == 4'd2) |=> (ea[AW-1:DW] == '0 && ea[DW-1:0] == $past(opb1)));
  p_imm_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mode == 4'd1) |=> (imm_flag && imm_data == $past(opb1)));
  p_post_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (mode == 4'd8 || mode == 4'd9)) |=> (hx_we && hx_next == $past(hx) + AW'(1)));
  p_keep_hx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mode < 4'd8) |=> (!hx_we && hx_next == $past(hx)));
  p_illegal_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !hx_we);
endmodule

bind ea_gen ea_gen_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .hx(hx), .opb1(opb1),
  .done(done), .ea(ea), .imm_flag(imm_flag), .imm_data(imm_data),
  .hx_next(hx_next), .hx_we(hx_we), .illegal(illegal));

// File: tb/ea_gen_test.sv
module ea_gen_test;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, prebyte = 1'b0;
  logic [3:0]  mode = '0;
  logic [15:0] hx = '0, sp = '0, pc_next = '0;
  logic [7:0]  opb1 = '0, opb2 = '0;
  logic done, imm_flag, hx_we, illegal;
  logic [15:0] ea, br_target, hx_next;
  logic [7:0]  imm_data;
  logic [2:0]  inst_len;

  typedef struct packed {
    logic [15:0] ea;
    logic        imm;
    logic [7:0]  data;
    logic [2:0]  len;
    logic [15:0] tgt;
    logic [15:0] hxn;
    logic        we;
    logic        ill;
  } res_t;

  typedef struct {
    res_t  r;
    string tag;
  } item_t;

  item_t q[$];
  int checks = 0, fails = 0, cycles = 0;
  bit finished = 0;

  ea_gen uut (.clk, .rst_n, .start, .mode, .prebyte, .hx, .sp, .pc_next, .opb1, .opb2,
              .done, .ea, .imm_flag, .imm_data, .inst_len, .br_target, .hx_next,
              .hx_we, .illegal);

  always #10 clk = ~clk;

  function automatic res_t model(logic [3:0] m, logic pb, logic [15:0] x, logic [15:0] s,
                                 logic [15:0] pc, logic [7:0] b1, logic [7:0] b2);
    res_t r;
    logic [15:0] w;
    w = {b1, b2};
    r = '0;
    r.tgt = pc + {{8{b1[7]}}, b1};
    r.hxn = x;
    case (m)
      0: r.len = 1;
      1: begin r.len = 2; r.imm = 1; r.data = b1; end
      2: begin r.len = 2; r.ea = {8'h00, b1}; end
      3: begin r.len = 3; r.ea = w; end
      4: begin r.len = 2; r.ea = r.tgt; end
      5: begin r.len = 1; r.ea = x; end
      6: begin r.len = 2; r.ea = x + {8'h00, b1}; end
      7: begin r.len = 3; r.ea = x + w; end
      8: begin r.len = 1; r.ea = x; r.we = 1; r.hxn = x + 1; end
      9: begin r.len = 2; r.ea = x + {8'h00, b1}; r.we = 1; r.hxn = x + 1; end
      10: if (pb) begin r.len = 3; r.ea = s + {8'h00, b1}; end else r.ill = 1;
      11: if (pb) begin r.len = 4; r.ea = s + w; end else r.ill = 1;
      default: r.ill = 1;
    endcase
    return r;
  endfunction

  function automatic res_t observed();
    res_t r;
    r = '{ea, imm_flag, imm_data, inst_len, br_target, hx_next, hx_we, illegal};
    return r;
  endfunction

  task automatic check(bit ok, string tag, string act, string exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  task automatic drive(string tag, logic [3:0] m, logic pb, logic [15:0] x,
                       logic [15:0] s, logic [15:0] pc, logic [7:0] b1, logic [7:0] b2);
    item_t it;
    @(negedge clk);
    mode = m; prebyte = pb; hx = x; sp = s; pc_next = pc; opb1 = b1; opb2 = b2;
    start = 1'b1;
    it.r = model(m, pb, x, s, pc, b1, b2);
    it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    start = 1'b0;
  endtask

  always @(negedge clk) begin
    if (done) begin
      if (q.size() == 0) check(0, "R10 unexpected done", "done", "idle");
      else begin
        item_t it;
        res_t o;
        it = q.pop_front();
        o = observed();
        check(o == it.r, it.tag, $sformatf("%h", o), $sformatf("%h", it.r));
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      check(0, "watchdog", "running", "finished");
      finish_run();
    end
  end

  initial begin
    res_t held;
    repeat (2) @(negedge clk);
    check(observed() == '0 && done == 0, "R10 reset state", $sformatf("%h", observed()), "0");
    rst_n = 1'b1;
    drive("R7 inherent", 0, 0, 16'h1234, 16'h0100, 16'h2000, 8'hAA, 8'hBB);
    drive("R7 immediate", 1, 0, 16'h1234, 16'h0100, 16'h2000, 8'h5C, 8'h00);
    drive("R1 direct", 2, 0, 16'h1234, 16'h0100, 16'h2000, 8'hF7, 8'h11);
    drive("R2 extended", 3, 0, 16'h1234, 16'h0100, 16'h2000, 8'hE0, 8'h42);
    drive("R3 relative forward", 4, 0, 16'h0000, 16'h0000, 16'h3000, 8'h7F, 8'h00);
    drive("R3 relative back wrap", 4, 0, 16'h0000, 16'h0000, 16'h0010, 8'h80, 8'h00);
    drive("R4 index no offset", 5, 0, 16'hBEEF, 16'h0000, 16'h0000, 8'h12, 8'h34);
    drive("R4 index 8-bit wrap", 6, 0, 16'hFFF0, 16'h0000, 16'h0000, 8'h20, 8'h00);
    drive("R4 index 16-bit", 7, 0, 16'h0102, 16'h0000, 16'h0000, 8'hFF, 8'h10);
    drive("R5 stack 8-bit", 10, 1, 16'h0000, 16'h00F0, 16'h0000, 8'hFF, 8'h00);
    drive("R5 stack 16-bit wrap", 11, 1, 16'h0000, 16'hF000, 16'h0000, 8'h20, 8'h01);
    drive("R9 stack without prebyte", 10, 0, 16'h4444, 16'h00F0, 16'h0000, 8'h01, 8'h00);
    drive("R9 stack16 without prebyte", 11, 0, 16'h5555, 16'h00F0, 16'h0000, 8'h01, 8'h00);
    drive("R9 unassigned code", 13, 1, 16'h6666, 16'h00F0, 16'h0000, 8'h01, 8'h00);
    drive("R6 post-inc rollover", 8, 0, 16'hFFFF, 16'h0000, 16'h0000, 8'h00, 8'h00);
    drive("R6 post-inc offset rollover", 9, 0, 16'hFFFF, 16'h0000, 16'h0000, 8'h05, 8'h00);
    drive("R6 post-inc mid", 9, 1, 16'h00FF, 16'h0000, 16'h0000, 8'h01, 8'h00);
    drive("R8 extended keeps index", 3, 0, 16'h7777, 16'h0000, 16'h0000, 8'h00, 8'h01);
    @(negedge clk);
    held = observed();
    mode = 4'd6; hx = 16'h1111; opb1 = 8'h22; opb2 = 8'h33; sp = 16'h9999;
    repeat (3) @(negedge clk);
    check(observed() == held && done == 0, "R10 hold without start",
          $sformatf("%h", observed()), $sformatf("%h", held));
    check(q.size() == 0, "R10 all results seen", $sformatf("%0d", q.size()), "0");
    finish_run();
  end
endmodule